// File: doc/BRIEF.md
# RV32I Instruction Decoder with Immediate Generator

This block sits in the decode stage of a five-stage integer pipeline. It takes one 32-bit base-integer instruction word and returns, with no clock, everything the later stages need. That covers the three register indices and an immediate extended to the full data width. It also covers the ALU operation, the operand-source selects, the load/store controls, the write-back enable and source, and the branch and jump flags. The register file, the ALU arithmetic and the hazard logic are outside this block.

Upper-immediate instructions need no unit of their own. The immediate for the U format comes out already shifted into the upper 20 bits, so loading an upper immediate is an ADD of zero and the immediate. Adding an upper immediate to the PC is the same ADD with the PC as the A operand. The only difference between the two is the A-source select. System, fence and unrecognised opcodes turn into inert bubbles: they write no register, touch no memory and redirect nothing.

Top module: `rv32i_decoder`

## Requirements
- R1: Register indices are taken straight from the word: rs1 = bits 19:15, rs2 = bits 24:20, rd = bits 11:7, for every opcode.
- R2: I-format immediates (OP-IMM 0010011, LOAD 0000011, JALR 1100111) are bits 31:20 sign-extended. S-format immediates (STORE 0100011) are {bits 31:25, bits 11:7} sign-extended.
- R3: B-format (BRANCH 1100011) and J-format (JAL 1101111) immediates use the standard scrambled bit placement, are sign-extended from bit 31, and always have bit 0 equal to 0.
- R4: LUI (0110111) yields imm = bits 31:12 followed by twelve zeros, with A-source 2 (zero), B-source 1 (immediate), ALU op 0 (ADD), write enable set and write-back source 0 (ALU).
- R5: AUIPC (0010111) yields the same shifted immediate and the same controls as LUI, except that A-source is 1 (PC).
- R6: ALU op codes are ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9. For OP (0110011) they are picked by funct3 (bits 14:12), with bit 30 choosing SUB over ADD and SRA over SRL. For OP-IMM bit 30 only chooses SRA over SRL, and funct3 000 is always ADD. Register ops use B-source 0 and immediate ops use B-source 1. Both use A-source 0 (rs1) and write back from the ALU.
- R7: A load sets the read strobe, uses write-back source 1 (memory) and passes funct3 bits 1:0 as the access size and funct3 bit 2 as the unsigned flag. Its address is rs1 plus the immediate, computed with ADD.
- R8: A store sets the write strobe, clears the write enable and computes its address as rs1 plus the immediate with ADD.
- R9: A branch sets the branch flag, passes funct3 as the condition code and selects rs1, rs2 and SUB. It writes no register.
- R10: JAL sets the jal flag and JALR sets the jalr flag. Both set the write enable with write-back source 2 (PC+4). The target adder is fed PC plus the immediate for JAL and rs1 plus the immediate for JALR, both with ADD.
- R11: When rd is 0 the write enable is always 0.
- R12: SYSTEM (1110011), FENCE (0001111) and any other opcode decode as a bubble. All strobes, flags and the write enable are 0, the immediate is 0, the ALU op is ADD and all selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word under decode |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| rd_o | output | 5 | Destination register index |
| imm_o | output | 32 | Extended immediate |
| alu_op_o | output | 4 | ALU operation code |
| a_sel_o | output | 2 | A operand source: 0 rs1, 1 PC, 2 zero |
| b_sel_o | output | 1 | B operand source: 0 rs2, 1 immediate |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Load strobe |
| mem_wr_o | output | 1 | Store strobe |
| mem_size_o | output | 2 | Access size code (funct3 bits 1:0) |
| mem_uns_o | output | 1 | Zero-extend the loaded value |
| branch_o | output | 1 | Conditional branch |
| br_cond_o | output | 3 | Branch condition code (funct3) |
| jal_o | output | 1 | Direct jump |
| jalr_o | output | 1 | Register-indirect jump |

## Verification
The bench goes after the immediate extremes. The most negative branch and jump offsets would come out positive or misaligned if a scrambled bit were misplaced or bit 0 were left live. An all-ones upper immediate would lose its top bit or pick up low bits if the shift were wrong. It also feeds an OP-IMM add with bit 30 set, which a decoder that reused the register-op rule would turn into a subtract. It targets x0 with jumps and loads, which a missing rd guard would let write. Finally it sends system, fence and garbage opcodes with every field filled, which a decoder with a loose default would let through as loads, writes or a nonzero immediate.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int XLEN  = 32;
  localparam int REGW  = 5;
  localparam int OPW   = 7;
  localparam int F3W   = 3;

  localparam logic [OPW-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPW-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPW-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPW-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPW-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPW-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPW-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPW-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPW-1:0] OPC_OP     = 7'b0110011;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
    ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
    ALU_OR = 4'd8, ALU_AND = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {ASRC_RS1 = 2'd0, ASRC_PC = 2'd1, ASRC_ZERO = 2'd2} a_src_e;
  typedef enum logic {BSRC_RS2 = 1'b0, BSRC_IMM = 1'b1} b_src_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2} wb_src_e;

  typedef enum logic [2:0] {
    FMT_NONE, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
  } imm_fmt_e;

  typedef enum logic [2:0] {
    CLS_BUBBLE, CLS_REG, CLS_IMM, CLS_ADDR, CLS_CMP
  } alu_cls_e;
endpackage

// File: rtl/rvdec_imm_gen.sv
module rvdec_imm_gen
  import rvdec_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [31:7]  word_i,
  input  imm_fmt_e     fmt_i,
  output logic [W-1:0] imm_o
);
  function automatic logic [W-1:0] ext_i(logic [31:7] w);
    return {{(W-12){w[31]}}, w[31:20]};
  endfunction

  function automatic logic [W-1:0] ext_s(logic [31:7] w);
    return {{(W-12){w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [W-1:0] ext_b(logic [31:7] w);
    return {{(W-13){w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic logic [W-1:0] ext_j(logic [31:7] w);
    return {{(W-21){w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  function automatic logic [W-1:0] ext_u(logic [31:7] w);
    return {{(W-32){w[31]}}, w[31:12], 12'h000};
  endfunction

  always_comb begin
    unique case (fmt_i)
      FMT_I:   imm_o = ext_i(word_i);
      FMT_S:   imm_o = ext_s(word_i);
      FMT_B:   imm_o = ext_b(word_i);
      FMT_J:   imm_o = ext_j(word_i);
      FMT_U:   imm_o = ext_u(word_i);
      default: imm_o = '0;
    endcase
  end

  // sign bit always tracks instruction bit 31 for the extended formats
  always_comb begin
    if (fmt_i inside {FMT_I, FMT_S, FMT_B, FMT_J})
      assert_imm_sign_R2: assert (imm_o[W-1] == word_i[31])
        else $error("immediate sign lost");
    if (fmt_i inside {FMT_B, FMT_J})
      assert_ctl_align_R3: assert (imm_o[0] == 1'b0)
        else $error("branch/jump offset misaligned");
    if (fmt_i == FMT_U)
      assert_upper_low_zero_R4: assert (imm_o[11:0] == 12'h000)
        else $error("upper immediate low bits nonzero");
  end
endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [OPW-1:0]  opcode_i,
  input  logic [REGW-1:0] rd_i,
  output imm_fmt_e        fmt_o,
  output alu_cls_e        cls_o,
  output a_src_e          a_src_o,
  output b_src_e          b_src_o,
  output wb_src_e         wb_src_o,
  output logic            we_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            branch_o,
  output logic            jal_o,
  output logic            jalr_o,
  output logic            x0_drop_o,
  output logic            bubble_o
);
  logic we_raw;

  always_comb begin
    fmt_o    = FMT_NONE;
    cls_o    = CLS_BUBBLE;
    a_src_o  = ASRC_RS1;
    b_src_o  = BSRC_RS2;
    wb_src_o = WB_ALU;
    we_raw   = 1'b0;
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    branch_o = 1'b0;
    jal_o    = 1'b0;
    jalr_o   = 1'b0;
    bubble_o = 1'b0;
    unique case (opcode_i)
      OPC_LUI, OPC_AUIPC: begin
        fmt_o   = FMT_U;
        cls_o   = CLS_ADDR;
        a_src_o = (opcode_i == OPC_LUI) ? ASRC_ZERO : ASRC_PC;
        b_src_o = BSRC_IMM;
        we_raw  = 1'b1;
      end
      OPC_JAL: begin
        fmt_o    = FMT_J;
        cls_o    = CLS_ADDR;
        a_src_o  = ASRC_PC;
        b_src_o  = BSRC_IMM;
        wb_src_o = WB_LINK;
        we_raw   = 1'b1;
        jal_o    = 1'b1;
      end
      OPC_JALR: begin
        fmt_o    = FMT_I;
        cls_o    = CLS_ADDR;
        b_src_o  = BSRC_IMM;
        wb_src_o = WB_LINK;
        we_raw   = 1'b1;
        jalr_o   = 1'b1;
      end
      OPC_BRANCH: begin
        fmt_o    = FMT_B;
        cls_o    = CLS_CMP;
        branch_o = 1'b1;
      end
      OPC_LOAD: begin
        fmt_o    = FMT_I;
        cls_o    = CLS_ADDR;
        b_src_o  = BSRC_IMM;
        wb_src_o = WB_MEM;
        we_raw   = 1'b1;
        mem_rd_o = 1'b1;
      end
      OPC_STORE: begin
        fmt_o    = FMT_S;
        cls_o    = CLS_ADDR;
        b_src_o  = BSRC_IMM;
        mem_wr_o = 1'b1;
      end
      OPC_OPIMM: begin
        fmt_o   = FMT_I;
        cls_o   = CLS_IMM;
        b_src_o = BSRC_IMM;
        we_raw  = 1'b1;
      end
      OPC_OP: begin
        cls_o  = CLS_REG;
        we_raw = 1'b1;
      end
      default: bubble_o = 1'b1;  // system, fence and unknown opcodes
    endcase
  end

  assign x0_drop_o = we_raw && (rd_i == '0);
  assign we_o      = we_raw && !x0_drop_o;

  always_comb begin
    assert_mem_excl_R8: assert ($onehot0({mem_rd_o, mem_wr_o}))
      else $error("load and store both strobed");
    assert_redirect_excl_R10: assert ($onehot0({branch_o, jal_o, jalr_o}))
      else $error("more than one redirect flag");
    if (jal_o || jalr_o)
      assert_link_src_R10: assert (wb_src_o == WB_LINK)
        else $error("jump without link write-back");
  end
endmodule

// File: rtl/rvdec_alu_sel.sv
module rvdec_alu_sel
  import rvdec_pkg::*;
(
  input  alu_cls_e       cls_i,
  input  logic [F3W-1:0] f3_i,
  input  logic           alt_i,
  output alu_op_e        op_o
);
  function automatic alu_op_e by_funct(logic [F3W-1:0] f3, logic sub_ok, logic alt);
    unique case (f3)
      3'b000:  return (sub_ok && alt) ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  always_comb begin
    unique case (cls_i)
      CLS_REG: op_o = by_funct(f3_i, 1'b1, alt_i);
      CLS_IMM: op_o = by_funct(f3_i, 1'b0, alt_i);
      CLS_CMP: op_o = ALU_SUB;
      default: op_o = ALU_ADD;
    endcase
  end

  always_comb begin
    if (cls_i == CLS_IMM)
      assert_no_subi_R6: assert (op_o != ALU_SUB)
        else $error("subtract decoded for immediate op");
    if (cls_i inside {CLS_ADDR, CLS_BUBBLE})
      assert_addr_add_R7: assert (op_o == ALU_ADD)
        else $error("address class not ADD");
  end
endmodule

// File: rtl/rv32i_decoder.sv
module rv32i_decoder
  import rvdec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [4:0]  rd_o,
  output logic [31:0] imm_o,
  output logic [3:0]  alu_op_o,
  output logic [1:0]  a_sel_o,
  output logic        b_sel_o,
  output logic [1:0]  wb_sel_o,
  output logic        reg_we_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [1:0]  mem_size_o,
  output logic        mem_uns_o,
  output logic        branch_o,
  output logic [2:0]  br_cond_o,
  output logic        jal_o,
  output logic        jalr_o
);
  imm_fmt_e fmt_w;
  alu_cls_e cls_w;
  a_src_e   a_src_w;
  b_src_e   b_src_w;
  wb_src_e  wb_src_w;
  alu_op_e  alu_op_w;
  logic     x0_drop_w;
  logic     bubble_w;
  logic [F3W-1:0] f3_w;

  assign f3_w  = instr_i[14:12];
  assign rs1_o = instr_i[19:15];
  assign rs2_o = instr_i[24:20];
  assign rd_o  = instr_i[11:7];

  rvdec_ctrl u_ctrl (
    .opcode_i (instr_i[6:0]),
    .rd_i     (instr_i[11:7]),
    .fmt_o    (fmt_w),
    .cls_o    (cls_w),
    .a_src_o  (a_src_w),
    .b_src_o  (b_src_w),
    .wb_src_o (wb_src_w),
    .we_o     (reg_we_o),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .branch_o (branch_o),
    .jal_o    (jal_o),
    .jalr_o   (jalr_o),
    .x0_drop_o(x0_drop_w),
    .bubble_o (bubble_w)
  );

  rvdec_imm_gen #(.W(XLEN)) u_imm (
    .word_i(instr_i[31:7]),
    .fmt_i (fmt_w),
    .imm_o (imm_o)
  );

  rvdec_alu_sel u_alu (
    .cls_i(cls_w),
    .f3_i (f3_w),
    .alt_i(instr_i[30]),
    .op_o (alu_op_w)
  );

  assign alu_op_o   = alu_op_w;
  assign a_sel_o    = a_src_w;
  assign b_sel_o    = b_src_w;
  assign wb_sel_o   = wb_src_w;
  assign mem_size_o = (mem_rd_o || mem_wr_o) ? f3_w[1:0] : 2'b00;
  assign mem_uns_o  = mem_rd_o && f3_w[2];
  assign br_cond_o  = branch_o ? f3_w : 3'b000;

  always_comb begin
    if (rd_o == 5'd0)
      assert_x0_silent_R11: assert (!reg_we_o)
        else $error("write to x0 enabled");
    if (x0_drop_w)
      assert_drop_only_x0_R11: assert (rd_o == 5'd0)
        else $error("write dropped for nonzero rd");
    if (mem_wr_o)
      assert_store_no_wb_R8: assert (!reg_we_o)
        else $error("store writes a register");
    if (a_sel_o == 2'd2)
      assert_zero_a_add_R4: assert (b_sel_o && alu_op_o == 4'd0)
        else $error("zero-A path not immediate ADD");
    if (bubble_w)
      assert_bubble_inert_R12: assert (!reg_we_o && !mem_rd_o && !mem_wr_o &&
                                       !branch_o && !jal_o && !jalr_o && imm_o == '0)
        else $error("bubble has side effects");
  end
endmodule

// File: tb/rv32i_decoder_test.sv
module rv32i_decoder_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [31:0] instr;
  logic [4:0]  rs1, rs2, rd;
  logic [31:0] imm;
  logic [3:0]  alu_op;
  logic [1:0]  a_sel, wb_sel, mem_size;
  logic        b_sel, reg_we, mem_rd, mem_wr, mem_uns, branch, jal, jalr;
  logic [2:0]  br_cond;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rv32i_decoder uut (
    .instr_i(instr), .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd), .imm_o(imm),
    .alu_op_o(alu_op), .a_sel_o(a_sel), .b_sel_o(b_sel), .wb_sel_o(wb_sel),
    .reg_we_o(reg_we), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_size_o(mem_size), .mem_uns_o(mem_uns), .branch_o(branch),
    .br_cond_o(br_cond), .jal_o(jal), .jalr_o(jalr)
  );

  // encoders built from the field layout, independent of the design
  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] s2, logic [4:0] s1,
                                        logic [2:0] f3, logic [4:0] d);
    return {f7, s2, s1, f3, d, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(int v, logic [4:0] s1, logic [2:0] f3,
                                        logic [4:0] d, logic [6:0] op);
    logic [31:0] x = v;
    return {x[11:0], s1, f3, d, op};
  endfunction
  function automatic logic [31:0] enc_s(int v, logic [4:0] s2, logic [4:0] s1, logic [2:0] f3);
    logic [31:0] x = v;
    return {x[11:5], s2, s1, f3, x[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(int v, logic [4:0] s2, logic [4:0] s1, logic [2:0] f3);
    logic [31:0] x = v;
    return {x[12], x[10:5], s2, s1, f3, x[4:1], x[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(int v, logic [4:0] d);
    logic [31:0] x = v;
    return {x[20], x[10:1], x[11], x[19:12], d, 7'b1101111};
  endfunction

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    instr = w;
    #2;
  endtask

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // {alu,a,b,wb,we,rd,wr,br,jal,jalr}
  function automatic logic [31:0] ctl();
    return {17'd0, alu_op, a_sel, b_sel, wb_sel, reg_we, mem_rd, mem_wr, branch, jal, jalr};
  endfunction
  function automatic logic [31:0] ectl(int al, int a, int b, int wb, bit we, bit r, bit w,
                                       bit br, bit j, bit jr);
    logic [3:0] al4 = al[3:0];
    logic [1:0] a2 = a[1:0];
    logic [1:0] wb2 = wb[1:0];
    return {17'd0, al4, a2, b[0], wb2, we, r, w, br, j, jr};
  endfunction

  task automatic t_reset();
    apply(32'h0);
    chk("R12 zero word controls", ctl(), ectl(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    chk("R12 zero word imm", imm, 32'h0);
  endtask

  task automatic t_fields();
    apply(enc_r(7'h00, 5'd21, 5'd13, 3'b000, 5'd30));
    chk("R1 rs1", {27'd0, rs1}, 32'd13);
    chk("R1 rs2", {27'd0, rs2}, 32'd21);
    chk("R1 rd", {27'd0, rd}, 32'd30);
  endtask

  task automatic t_reg_ops();
    apply(enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3));
    chk("R6 ADD", ctl(), ectl(0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
    apply(enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd3));
    chk("R6 SUB", ctl(), ectl(1, 0, 0, 0, 1, 0, 0, 0, 0, 0));
    apply(enc_r(7'h20, 5'd2, 5'd1, 3'b101, 5'd3));
    chk("R6 SRA", {28'd0, alu_op}, 32'd7);
    apply(enc_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd3));
    chk("R6 AND", {28'd0, alu_op}, 32'd9);
    apply(enc_r(7'h00, 5'd2, 5'd1, 3'b011, 5'd3));
    chk("R6 SLTU", {28'd0, alu_op}, 32'd4);
  endtask

  task automatic t_imm_ops();
    apply(enc_i(-1024, 5'd4, 3'b000, 5'd5, 7'b0010011));  // bit 30 set by the value
    chk("R6 ADDI bit30 stays ADD", ctl(), ectl(0, 0, 1, 0, 1, 0, 0, 0, 0, 0));
    chk("R2 ADDI imm", imm, 32'hFFFFFC00);
    apply(enc_i(32'h403, 5'd4, 3'b101, 5'd5, 7'b0010011));
    chk("R6 SRAI", {28'd0, alu_op}, 32'd7);
    apply(enc_i(2047, 5'd4, 3'b110, 5'd5, 7'b0010011));
    chk("R2 ORI max imm", imm, 32'd2047);
    chk("R6 ORI op", {28'd0, alu_op}, 32'd8);
  endtask

  task automatic t_load();
    apply(enc_i(-2048, 5'd6, 3'b100, 5'd7, 7'b0000011));
    chk("R7 LBU controls", ctl(), ectl(0, 0, 1, 1, 1, 1, 0, 0, 0, 0));
    chk("R7 LBU size/uns", {29'd0, mem_size, mem_uns}, {29'd0, 2'b00, 1'b1});
    chk("R2 load imm", imm, 32'hFFFFF800);
    apply(enc_i(8, 5'd6, 3'b010, 5'd7, 7'b0000011));
    chk("R7 LW size/uns", {29'd0, mem_size, mem_uns}, {29'd0, 2'b10, 1'b0});
  endtask

  task automatic t_store();
    apply(enc_s(-3, 5'd9, 5'd8, 3'b001));
    chk("R8 SH controls", ctl(), ectl(0, 0, 1, 0, 0, 0, 1, 0, 0, 0));
    chk("R2 S imm", imm, 32'hFFFFFFFD);
    chk("R8 SH size", {30'd0, mem_size}, 32'd1);
  endtask

  task automatic t_branch();
    apply(enc_b(-4096, 5'd11, 5'd10, 3'b001));
    chk("R9 BNE controls", ctl(), ectl(1, 0, 0, 0, 0, 0, 0, 1, 0, 0));
    chk("R3 B min imm", imm, 32'hFFFFF000);
    chk("R9 cond", {29'd0, br_cond}, 32'd1);
    apply(enc_b(4094, 5'd11, 5'd10, 3'b111) | 32'h0000_0000);
    chk("R3 B max imm", imm, 32'd4094);
    apply(32'hFFFF_FFE3);  // branch with every other bit set
    chk("R3 B bit0 clear", {31'd0, imm[0]}, 32'd0);
  endtask

  task automatic t_upper();
    apply({20'hFFFFF, 5'd12, 7'b0110111});
    chk("R4 LUI imm", imm, 32'hFFFFF000);
    chk("R4 LUI controls", ctl(), ectl(0, 2, 1, 0, 1, 0, 0, 0, 0, 0));
    apply({20'h12345, 5'd12, 7'b0010111});
    chk("R5 AUIPC imm", imm, 32'h12345000);
    chk("R5 AUIPC controls", ctl(), ectl(0, 1, 1, 0, 1, 0, 0, 0, 0, 0));
  endtask

  task automatic t_jumps();
    apply(enc_j(-1048576, 5'd1));
    chk("R10 JAL controls", ctl(), ectl(0, 1, 1, 2, 1, 0, 0, 0, 1, 0));
    chk("R3 J min imm", imm, 32'hFFF00000);
    apply(enc_j(1048574, 5'd1));
    chk("R3 J max imm", imm, 32'h000FFFFE);
    apply(enc_i(-4, 5'd14, 3'b000, 5'd15, 7'b1100111));
    chk("R10 JALR controls", ctl(), ectl(0, 0, 1, 2, 1, 0, 0, 0, 0, 1));
    chk("R2 JALR imm", imm, 32'hFFFFFFFC);
  endtask

  task automatic t_x0();
    apply(enc_j(16, 5'd0));
    chk("R11 JAL x0 no write", {31'd0, reg_we}, 32'd0);
    chk("R11 JAL x0 still jumps", {31'd0, jal}, 32'd1);
    apply(enc_i(4, 5'd3, 3'b010, 5'd0, 7'b0000011));
    chk("R11 load x0 no write", {31'd0, reg_we}, 32'd0);
    apply({20'hABCDE, 5'd0, 7'b0110111});
    chk("R11 LUI x0 no write", {31'd0, reg_we}, 32'd0);
  endtask

  task automatic t_bubbles();
    apply(32'h0000_0073);  // system call
    chk("R12 SYSTEM controls", ctl(), ectl(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    apply(32'hFFFF_FFF3);  // system, all fields set
    chk("R12 SYSTEM full", ctl(), ectl(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    chk("R12 SYSTEM imm", imm, 32'h0);
    apply(32'h0FF0_000F);  // fence
    chk("R12 FENCE controls", ctl(), ectl(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    apply(32'hFFFF_FFFF);  // unknown opcode
    chk("R12 unknown controls", ctl(), ectl(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    chk("R12 unknown imm", imm, 32'h0);
    chk("R12 unknown mem fields", {27'd0, mem_size, mem_uns, br_cond[1:0]}, 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    instr = 32'h0;
    repeat (2) @(negedge clk);
    t_reset();
    t_fields();
    t_reg_ops();
    t_imm_ops();
    t_load();
    t_store();
    t_branch();
    t_upper();
    t_jumps();
    t_x0();
    t_bubbles();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      finish_run();
    end
  end
endmodule